// File: doc/BRIEF.md
# Serial Receiver with Sticky Status Flags

This block turns an asynchronous serial line into bytes. A sampling strobe runs at sixteen times the baud rate and paces every timing decision. The line first passes through a two-stage synchronizer. While idle the line sits high. A low level is only a candidate start bit. The receiver takes it as a real start only if the line is still low half a bit later, and otherwise it goes back to waiting.

After a valid start, the block takes eight data bits at their bit centres, least significant bit first. It then takes an optional parity bit and one stop bit. The finished character goes into a holding register that the host reads.

Four status flags tell the host what happened:

- **Ready** means a character is waiting. It drops on its own when the host reads the holding register.
- **Overrun** means a character arrived while ready was still set.
- **Parity error** and **framing error** report bad parity and a low stop bit.

Overrun, parity error and framing error stay set until the host sends a separate reset-status command. A read alone therefore never hides a lost character.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rdy`, `ovr`, `perr` and `ferr` are 0 and `rx_data` is 0x00.
- R2: A low level seen while idle is accepted as a start bit only if the synchronized line is still low 8 sampling strobes later. Otherwise the receiver returns to idle and loads nothing.
- R3: Data bits are sampled every 16 strobes at the bit centres, least significant bit first, 8 bits per character. `rx_data` bit 0 holds the first bit received.
- R4: With `par_en`=1, a parity bit follows the eighth data bit. With `par_odd`=0 the expected parity makes the count of ones in data plus parity even. With `par_odd`=1 that count must be odd. A mismatch sets `perr` when the character completes.
- R5: The stop bit is sampled at its centre. If it is low, `ferr` is set when the character completes.
- R6: When a character completes, it is loaded into `rx_data` and `rdy` is set.
- R7: A one-cycle `rd_stb` pulse clears `rdy` on the next clock edge, provided no character completes in that cycle.
- R8: If a character completes while `rdy` is set and no read occurs in that cycle, `ovr` is set. The new character overwrites `rx_data` and `rdy` stays 1.
- R9: `ovr`, `perr` and `ferr` remain set until `clr_stb` is pulsed. `clr_stb` clears them, but a new error event in the same cycle wins. `clr_stb` does not affect `rdy`.
- R10: If `rd_stb` and a character completion coincide, the completion wins. `rdy` stays 1 and `ovr` is not set.
- R11: `rx_line` passes through two synchronizing flops. All sampling uses the synchronized value, and every timing count advances only on cycles where `os_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Sampling strobe at 16x the baud rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| par_en | input | 1 | 1 = a parity bit follows the data bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_stb | input | 1 | Host read of the holding register |
| clr_stb | input | 1 | Host reset-status command |
| rx_data | output | 8 | Receive holding register |
| rdy | output | 1 | Character waiting |
| ovr | output | 1 | Overrun, sticky |
| perr | output | 1 | Parity error, sticky |
| ferr | output | 1 | Framing error, sticky |

## Verification
The bench sends a short low glitch that fails the half-bit recheck. A receiver that skips the recheck would load a spurious character and raise `rdy`.

It sends two characters with no read in between. A design that kept the older byte, or dropped `rdy`, would show the wrong `rx_data` or a cleared flag. A plain read must leave `ovr` standing, and only `clr_stb` may drop it.

The bench sends frames with correct and with wrong parity in both parity senses, and a frame with a low stop bit. This catches an inverted parity sense and a stop bit that is never checked.

Last, it pulses a read in exactly the cycle a character completes. A design that lets the read win would end with `rdy` low. A design that treats the completion as an overrun would raise `ovr`.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rx_line,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_stb,
  input  logic          clr_stb,
  output logic [DW-1:0] rx_data,
  output logic          rdy,
  output logic          ovr,
  output logic          perr,
  output logic          ferr
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = (DW > 1) ? $clog2(DW) : 1;
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          pbit, sync1, line_s;
  logic          mid_tick, last_tick, done, par_bad, stop_bad;

  // R11: two-flop synchronizer, idle high
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, line_s} <= 2'b11;
    else        {sync1, line_s} <= {rx_line, sync1};

  assign mid_tick  = os_tick && cnt == CW'(HALF - 1);
  assign last_tick = os_tick && cnt == CW'(OVS - 1);
  assign done      = st == STOP && last_tick;
  assign stop_bad  = !line_s;
  assign par_bad   = par_en && (pbit != (^shreg ^ par_odd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bidx <= '0; shreg <= '0; pbit <= 1'b0;
    end else if (os_tick) begin
      cnt <= cnt + 1'b1;
      unique case (st)
        IDLE: begin
          cnt <= '0;
          if (!line_s) st <= START;
        end
        START: if (mid_tick) begin
          cnt <= '0;
          bidx <= '0;
          st <= line_s ? IDLE : DATA;
        end
        DATA: if (last_tick) begin
          shreg <= {line_s, shreg[DW-1:1]};
          bidx <= bidx + 1'b1;
          if (bidx == IW'(DW - 1)) st <= par_en ? PAR : STOP;
        end
        PAR: if (last_tick) begin
          pbit <= line_s;
          st <= STOP;
        end
        STOP: if (last_tick) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rdy <= 1'b0; ovr <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      if (clr_stb) {ovr, perr, ferr} <= 3'b000;
      if (done) begin
        rx_data <= shreg;
        rdy <= 1'b1;
        if (rdy && !rd_stb) ovr <= 1'b1;
        if (par_bad) perr <= 1'b1;
        if (stop_bad) ferr <= 1'b1;
      end else if (rd_stb) begin
        rdy <= 1'b0;
      end
    end
  end

  // R6
  rdy_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy);
  // R7
  rdy_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done) |=> !rdy);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_stb) |=> ovr);
  // R8
  ovr_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rdy));
  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && line_s) |=> st == IDLE);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((perr || ferr) && !clr_stb) |=> (perr || ferr));
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b1, rx_line = 1'b1;
  logic par_en = 1'b0, par_odd = 1'b0, rd_stb = 1'b0, clr_stb = 1'b0;
  logic [7:0] rx_data;
  logic rdy, ovr, perr, ferr;
  int nvec = 0, nbad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_rx_status dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb), .clr_stb(clr_stb),
    .rx_data(rx_data), .rdy(rdy), .ovr(ovr), .perr(perr), .ferr(ferr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(logic v);
    rx_line = v;
    repeat (16) @(negedge clk);
  endtask

  // rd_at >= 0 pulses rd_stb that many negedges after the start bit begins
  task automatic send(logic [7:0] d, bit use_par, bit par_wrong, bit stop_low, int rd_at);
    @(negedge clk);
    fork
      begin
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (use_par) hold_bit((^d ^ par_odd) ^ par_wrong);
        hold_bit(!stop_low);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
      end
      begin
        if (rd_at >= 0) begin
          repeat (rd_at) @(negedge clk);
          rd_stb = 1'b1;
          @(negedge clk);
          rd_stb = 1'b0;
        end
      end
    join
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_stb = 1'b1; @(negedge clk); clr_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdy", rdy, 0); chk("R1 ovr", ovr, 0);
    chk("R1 perr", perr, 0); chk("R1 ferr", ferr, 0);
    chk("R1 data", rx_data, 8'h00);
  endtask

  task automatic t_basic();
    send(8'hA5, 0, 0, 0, -1);
    chk("R3/R11 data A5", rx_data, 8'hA5); chk("R6 rdy", rdy, 1);
    chk("R5 ferr clean", ferr, 0);
    pulse_rd(); @(negedge clk);
    chk("R7 rdy cleared", rdy, 0);
    send(8'h3C, 0, 0, 0, -1);
    chk("R3 data 3C lsb first", rx_data, 8'h3C);
    pulse_rd();
  endtask

  task automatic t_false_start();
    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk); rx_line = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 glitch no rdy", rdy, 0);
    chk("R2 glitch data kept", rx_data, 8'h3C);
    send(8'h81, 0, 0, 0, -1);
    chk("R2 frame after glitch", rx_data, 8'h81);
    pulse_rd();
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h07, 1, 0, 0, -1);
    chk("R4 even ok data", rx_data, 8'h07); chk("R4 even ok perr", perr, 0);
    pulse_rd();
    send(8'h07, 1, 1, 0, -1);
    chk("R4 even bad perr", perr, 1);
    pulse_rd();
    pulse_rd(); @(negedge clk);
    chk("R9 perr kept after read", perr, 1);
    pulse_clr(); @(negedge clk);
    chk("R9 perr cleared", perr, 0);
    par_odd = 1'b1;
    send(8'h5A, 1, 0, 0, -1);
    chk("R4 odd ok perr", perr, 0); chk("R4 odd data", rx_data, 8'h5A);
    pulse_rd();
    send(8'h5A, 1, 1, 0, -1);
    chk("R4 odd bad perr", perr, 1);
    pulse_rd(); pulse_clr();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_framing();
    send(8'hC3, 0, 0, 1, -1);
    chk("R5 ferr set", ferr, 1); chk("R5 data", rx_data, 8'hC3);
    pulse_rd(); pulse_clr(); @(negedge clk);
    chk("R9 ferr cleared", ferr, 0);
    chk("R2 no restart from low stop", rdy, 0);
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 0, 0, -1);
    send(8'h22, 0, 0, 0, -1);
    chk("R8 ovr set", ovr, 1); chk("R8 rdy stays", rdy, 1);
    chk("R8 new data", rx_data, 8'h22);
    pulse_rd(); @(negedge clk);
    chk("R9 ovr after read", ovr, 1); chk("R7 rdy after read", rdy, 0);
    pulse_clr(); @(negedge clk);
    chk("R9 ovr cleared", ovr, 0);
  endtask

  task automatic t_simul();
    send(8'h44, 0, 0, 0, -1);
    chk("R6 first ready", rdy, 1);
    send(8'h99, 0, 0, 0, 154);
    chk("R10 rdy stays", rdy, 1); chk("R10 no ovr", ovr, 0);
    chk("R10 data", rx_data, 8'h99);
    pulse_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_basic();
    t_false_start();
    t_parity();
    t_framing();
    t_overrun();
    t_simul();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule